// File: doc/BRIEF.md
# Eight-Bit Arithmetic Unit with Status Flags

This block is the arithmetic core of a small eight-bit processor datapath. Each cycle it takes the accumulator value, a second operand, the incoming carry and a three-bit operation code. It produces, combinationally, the new accumulator value and the value to be written back to the second operand. Valid operations are add, add with carry, subtract with borrow, increment, decrement, low-nibble exchange and an unsigned 8x8 multiply.

When `en_i` is high, the rising clock edge loads the carry, auxiliary carry and signed overflow flags, along with the multiply high-byte register. Parity is not stored. It is produced continuously as the even-parity bit of the accumulator input.

The operation codes on `op_i` are: 0 add, 1 add with carry, 2 subtract with borrow, 3 increment, 4 decrement, 5 nibble exchange, 6 multiply, 7 no operation. Instruction fetch, decode, operand addressing and division are handled elsewhere.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cy_o`, `ac_o`, `ov_o` and `b_o` are all zero.
- R2: Op 0 drives `res_o` = (acc + opnd) mod 256. Op 1 drives `res_o` = (acc + opnd + `cy_i`) mod 256. With `en_i` high, `cy_o` is then loaded with the carry out of bit 7.
- R3: Op 2 drives `res_o` = (acc − opnd − `cy_i`) mod 256, so the incoming carry is always subtracted. With `en_i` high, `cy_o` is then loaded with 1 exactly when the unsigned difference is negative.
- R4: On ops 0, 1 and 2 with `en_i` high, `ac_o` is loaded with one of two values. For add it is the carry out of bit 3. For subtract it is 1 when the low-nibble difference (including the borrow) is negative.
- R5: On ops 0, 1 and 2 with `en_i` high, `ov_o` is loaded with 1 exactly when the signed result lies outside −128..+127.
- R6: `par_o` equals the XOR of all bits of `acc_i` at all times, so the ones in `acc_i` plus `par_o` are even.
- R7: Op 3 drives `res_o` = (opnd + 1) mod 256 and op 4 drives `res_o` = (opnd − 1) mod 256. Neither op changes `cy_o`, `ac_o` or `ov_o`.
- R8: Op 5 drives `res_o` = {acc[7:4], opnd[3:0]} and `opnd_o` = {opnd[7:4], acc[3:0]}, with flags unchanged. For every other op, `opnd_o` equals `opnd_i`.
- R9: Op 6 drives `res_o` with the low byte of acc × opnd. With `en_i` high, it loads the high byte into `b_o`, clears `cy_o`, sets `ov_o` exactly when the product exceeds 255, and leaves `ac_o` unchanged.
- R10: With `en_i` low, or on op 7, no flag and `b_o` does not change. Op 7 drives `res_o` = `acc_i`. `b_o` changes only on op 6 with `en_i` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Commit flags and high byte at the clock edge |
| op_i | input | 3 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| cy_i | input | 1 | Incoming carry / borrow |
| res_o | output | 8 | New accumulator value |
| opnd_o | output | 8 | Value written back to the second operand |
| b_o | output | 8 | Registered multiply high byte |
| cy_o | output | 1 | Registered carry flag |
| ac_o | output | 1 | Registered auxiliary carry flag |
| ov_o | output | 1 | Registered signed overflow flag |
| par_o | output | 1 | Even-parity bit of the accumulator |

## Verification
The hardest cases to reach are the exact boundaries: a product of exactly 255 against exactly 256, and a signed overflow caused only by the incoming borrow (for example 0x80 minus 0 minus 1). Random operands rarely hit these values, so a directed prelude drives them first. A long random run then follows, and a behavioural integer model checks every output against the design on every cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUBB = 3'd2,
        OP_INC  = 3'd3,
        OP_DEC  = 3'd4,
        OP_XCHD = 3'd5,
        OP_MUL  = 3'd6,
        OP_NOP  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } alu_flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         acout_o,
    output logic         ovout_o
);
    localparam int NIB = W / 2;

    logic [W-1:0]   b_eff;
    logic           c_eff;
    logic [W:0]     full;
    logic [NIB:0]   low;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        c_eff   = sub_i ? ~cin_i : cin_i;
        full    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        low     = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
        sum_o   = full[W-1:0];
        cout_o  = full[W] ^ sub_i;
        acout_o = low[NIB] ^ sub_i;
        ovout_o = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] pp [W];

    for (genvar i = 0; i < W; i++) begin : g_pp
        assign pp[i] = b_i[i] ? ({{W{1'b0}}, a_i} << i) : '0;
    end

    always_comb begin
        prod_o = '0;
        for (int k = 0; k < W; k++) begin
            prod_o = prod_o + pp[k];
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic         cy_i,
    output logic [W-1:0] res_o,
    output logic [W-1:0] opnd_o,
    output logic [W-1:0] b_o,
    output logic         cy_o,
    output logic         ac_o,
    output logic         ov_o,
    output logic         par_o
);
    localparam int NIB = W / 2;
    localparam int PW  = 2 * W;

    alu_op_e    op;
    alu_flags_t flg_q, flg_d;
    logic [W-1:0] b_q, b_d;

    logic [W-1:0]  as_sum;
    logic          as_cout, as_acout, as_ovout;
    logic          as_sub, as_cin;
    logic [PW-1:0] prod;

    assign op     = alu_op_e'(op_i);
    assign as_sub = (op == OP_SUBB);
    assign as_cin = (op == OP_ADD) ? 1'b0 : cy_i;

    alu8_addsub #(.W(W)) u_addsub (
        .a_i     (acc_i),
        .b_i     (opnd_i),
        .cin_i   (as_cin),
        .sub_i   (as_sub),
        .sum_o   (as_sum),
        .cout_o  (as_cout),
        .acout_o (as_acout),
        .ovout_o (as_ovout)
    );

    alu8_mul #(.W(W)) u_mul (
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .prod_o (prod)
    );

    always_comb begin
        res_o  = acc_i;
        opnd_o = opnd_i;
        flg_d  = flg_q;
        b_d    = b_q;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                res_o = as_sum;
                flg_d = '{cy: as_cout, ac: as_acout, ov: as_ovout};
            end
            OP_INC: res_o = opnd_i + 1'b1;
            OP_DEC: res_o = opnd_i - 1'b1;
            OP_XCHD: begin
                res_o  = {acc_i[W-1:NIB], opnd_i[NIB-1:0]};
                opnd_o = {opnd_i[W-1:NIB], acc_i[NIB-1:0]};
            end
            OP_MUL: begin
                res_o    = prod[W-1:0];
                b_d      = prod[PW-1:W];
                flg_d.cy = 1'b0;
                flg_d.ov = |prod[PW-1:W];
            end
            OP_NOP: res_o = acc_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
            b_q   <= '0;
        end else if (en_i) begin
            flg_q <= flg_d;
            b_q   <= b_d;
        end
    end

    assign cy_o  = flg_q.cy;
    assign ac_o  = flg_q.ac;
    assign ov_o  = flg_q.ov;
    assign b_o   = b_q;
    assign par_o = ^acc_i;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_i,
    input logic [2:0]   op_i,
    input logic [W-1:0] b_o,
    input logic         cy_o,
    input logic         ac_o,
    input logic         ov_o
);
    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || op_i == 3'd7) |=> $stable({cy_o, ac_o, ov_o, b_o}));

    assert_incdec_keep_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (op_i == 3'd3 || op_i == 3'd4)) |=> $stable({cy_o, ac_o, ov_o}));

    assert_xchd_keep_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == 3'd5) |=> $stable({cy_o, ac_o, ov_o}));

    assert_mul_carry_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == 3'd6) |=> (!cy_o && $stable(ac_o) && (ov_o == (b_o != '0))));

    assert_b_only_on_mul_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && op_i == 3'd6) |=> $stable(b_o));

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (b_o == '0 && !cy_o && !ac_o && !ov_o));
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en_i),
    .op_i  (op_i),
    .b_o   (b_o),
    .cy_o  (cy_o),
    .ac_o  (ac_o),
    .ov_o  (ov_o)
);

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [2:0] op_i = 3'd7;
    logic [7:0] acc_i = 8'd0;
    logic [7:0] opnd_i = 8'd0;
    logic       cy_i = 1'b0;
    logic [7:0] res_o, opnd_o, b_o;
    logic       cy_o, ac_o, ov_o, par_o;

    int n_chk = 0;
    int n_bad = 0;
    int e_cy = 0, e_ac = 0, e_ov = 0, e_b = 0;

    always #10 clk = ~clk;

    alu8_core u_alu8_core (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .cy_i(cy_i),
        .res_o(res_o), .opnd_o(opnd_o), .b_o(b_o),
        .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o), .par_o(par_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int sgn(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    task automatic check_regs(input string tag);
        chk({tag, " cy"}, int'(cy_o), e_cy);
        chk({tag, " ac"}, int'(ac_o), e_ac);
        chk({tag, " ov"}, int'(ov_o), e_ov);
        chk({tag, " b"},  int'(b_o),  e_b);
    endtask

    task automatic step(input int op, input int a, input int o, input int c, input int en);
        int r, w, t, s, n_cy, n_ac, n_ov, n_b, par;
        string tag;
        @(negedge clk);
        op_i = op[2:0]; acc_i = a[7:0]; opnd_i = o[7:0]; cy_i = c[0]; en_i = en[0];
        #1;
        r = a; w = o; n_cy = e_cy; n_ac = e_ac; n_ov = e_ov; n_b = e_b;
        case (op)
            0, 1: begin
                t = (op == 1) ? c : 0;
                s = a + o + t;
                r = s % 256;
                n_cy = (s > 255) ? 1 : 0;
                n_ac = ((a % 16) + (o % 16) + t > 15) ? 1 : 0;
                s = sgn(a) + sgn(o) + t;
                n_ov = (s > 127 || s < -128) ? 1 : 0;
            end
            2: begin
                s = a - o - c;
                r = (s + 256) % 256;
                n_cy = (s < 0) ? 1 : 0;
                n_ac = ((a % 16) - (o % 16) - c < 0) ? 1 : 0;
                s = sgn(a) - sgn(o) - c;
                n_ov = (s > 127 || s < -128) ? 1 : 0;
            end
            3: r = (o + 1) % 256;
            4: r = (o + 255) % 256;
            5: begin
                r = (a / 16) * 16 + (o % 16);
                w = (o / 16) * 16 + (a % 16);
            end
            6: begin
                s = a * o;
                r = s % 256;
                n_b = s / 256;
                n_cy = 0;
                n_ov = (s > 255) ? 1 : 0;
            end
            default: r = a;
        endcase
        par = 0;
        for (int i = 0; i < 8; i++) par = par ^ ((a >> i) & 1);
        case (op)
            0, 1: tag = "R2";
            2: tag = "R3";
            3, 4: tag = "R7";
            5: tag = "R8";
            6: tag = "R9";
            default: tag = "R10";
        endcase
        chk({tag, " res"}, int'(res_o), r);
        chk("R8 opnd_o", int'(opnd_o), w);
        chk("R6 parity", int'(par_o), par);
        if (en != 0) begin
            e_cy = n_cy; e_ac = n_ac; e_ov = n_ov; e_b = n_b;
        end
        @(posedge clk);
        #1;
        if (op == 0 || op == 1 || op == 2) tag = "R4 R5";
        if (en == 0) tag = "R10";
        check_regs(tag);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_regs("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_regs("R1 after reset");

        step(0, 8'h7F, 8'h01, 1, 1);   // R5 signed overflow, R4 nibble carry
        step(0, 8'hFF, 8'h01, 0, 1);   // R2 carry out
        step(1, 8'h10, 8'h20, 1, 1);   // R2 carry in used
        step(2, 8'h80, 8'h00, 1, 1);   // R3/R5 overflow from borrow alone
        step(2, 8'h00, 8'h00, 1, 1);   // R3 borrow wraps
        step(2, 8'h10, 8'h01, 0, 1);   // R4 nibble borrow
        step(3, 8'h00, 8'hFF, 1, 1);   // R7 increment wraps
        step(4, 8'h00, 8'h00, 0, 1);   // R7 decrement wraps
        step(5, 8'hA5, 8'h3C, 0, 1);   // R8 nibble exchange
        step(6, 8'h0F, 8'h11, 0, 1);   // R9 product 255, no OV
        step(6, 8'h10, 8'h10, 1, 1);   // R9 product 256, OV
        step(6, 8'hFF, 8'hFF, 1, 0);   // R10 disabled multiply
        step(7, 8'h5A, 8'hFF, 1, 1);   // R10 no-op
        step(6, 8'hFF, 8'hFF, 0, 1);   // R9 largest product
        for (int k = 0; k < 3000; k++) begin
            step(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 1)),
                 ($urandom_range(0, 3) != 0) ? 1 : 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule